// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block predicts the result value of register-writing instructions, one table entry per instruction. Each entry holds the last result seen, two strides and a 2-bit confidence counter. A lookup with an instruction address returns the last value plus the entry's prediction stride, and a flag that says whether the prediction has proved reliable lately. When the instruction completes, an update with the same address and the true result trains the entry.

Stride hysteresis follows the two-delta rule. The newest difference between consecutive results is always stored in a scratch stride. The prediction stride takes that difference only when the same difference turns up on two updates in a row. A single outlier result therefore does not disturb a long-running stride. Whether a prediction is right is tracked apart from the value data by the saturating confidence counter. The table is direct-mapped on the low address bits and tagged with the remaining bits, so instructions that share an index do not train each other.

Top module: `stride_vpred`

## Requirements
- R1: After reset every entry is invalid. Any lookup then reports `pred_hit`=0, `pred_confident`=0 and `pred_value`=0.
- R2: A lookup presented in one cycle reports its result in the next cycle. The result reflects the table as it stood before any update taken in the same cycle, including an update to the same entry.
- R3: On a hit, `pred_value` equals the entry's last value plus its prediction stride, computed modulo 2^32.
- R4: On each update that hits, the scratch stride becomes (result − last value). The prediction stride takes that same difference only when it equals the scratch stride held before the update. Otherwise the prediction stride is unchanged.
- R5: The 2-bit confidence counter increments on a correct prediction, saturating at 3, and decrements on a wrong one, saturating at 0. `pred_confident` is 1 only on a hit whose counter is 2 or 3.
- R6: An update that misses allocates the entry: tag set, last value set to the result, both strides set to 0, confidence set to 0. This replaces any other instruction that held the index.
- R7: Correctness is judged by comparing the result with the prediction (last value + prediction stride) as it stood before the update.
- R8: A lookup with `lk_writes_reg`=0 reports a miss. An update with `upd_writes_reg`=0 leaves the table unchanged.
- R9: The index is the low log2(ENTRIES) address bits and the tag is the remaining bits. A lookup whose tag differs from the stored tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_writes_reg | input | 1 | Looked-up instruction writes a register |
| lk_pc | input | PC_W | Instruction address for the lookup |
| pred_hit | output | 1 | Registered: lookup found a trained entry |
| pred_value | output | VAL_W | Registered: predicted result (0 on a miss) |
| pred_confident | output | 1 | Registered: prediction is trusted |
| upd_valid | input | 1 | Update request at completion |
| upd_writes_reg | input | 1 | Completing instruction writes a register |
| upd_pc | input | PC_W | Instruction address for the update |
| upd_result | input | VAL_W | True result of the instruction |

## Verification
Lookup results are registered. A lookup driven just after one rising edge shows on `pred_*` after the next rising edge. The bench drives on the falling edge and samples on the following falling edge. An update is written at the rising edge that follows its driving. A lookup issued in that same cycle therefore sees the old entry, and any later lookup sees the new one. The bench's reference table is changed at exactly that point, after the expected lookup value has been taken. Directed stride, outlier, aliasing, wrap-around and non-writing cases are followed by seeded random streams of constant, strided, stride-changing and random results.

// File: rtl/svp_pkg.sv
package svp_pkg;
  typedef logic [1:0] conf_t;
  localparam conf_t CONF_MAX    = 2'd3;
  localparam conf_t CONF_TRUST  = 2'd2;

  // saturating step of the confidence counter
  function automatic conf_t conf_step(input conf_t c, input logic good);
    if (good) return (c == CONF_MAX) ? c : conf_t'(c + 2'd1);
    else      return (c == 2'd0)     ? c : conf_t'(c - 2'd1);
  endfunction

  function automatic logic conf_trusted(input conf_t c);
    return c >= CONF_TRUST;
  endfunction
endpackage

// File: rtl/svp_table.sv
module svp_table
  import svp_pkg::*;
#(
  parameter int VAL_W   = 32,
  parameter int TAG_W   = 27,
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output logic [VAL_W-1:0] ra_last,
  output logic [VAL_W-1:0] ra_pstride,
  output conf_t            ra_conf,
  // read port B (update)
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output logic [VAL_W-1:0] rb_last,
  output logic [VAL_W-1:0] rb_sstride,
  output logic [VAL_W-1:0] rb_pstride,
  output conf_t            rb_conf,
  // write port
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [VAL_W-1:0] w_last,
  input  logic [VAL_W-1:0] w_sstride,
  input  logic [VAL_W-1:0] w_pstride,
  input  conf_t            w_conf
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [VAL_W-1:0]   last_q  [ENTRIES];
  logic [VAL_W-1:0]   sstr_q  [ENTRIES];
  logic [VAL_W-1:0]   pstr_q  [ENTRIES];
  conf_t              conf_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx]  <= w_tag;
      last_q[w_idx] <= w_last;
      sstr_q[w_idx] <= w_sstride;
      pstr_q[w_idx] <= w_pstride;
      conf_q[w_idx] <= w_conf;
    end
  end

  assign ra_valid   = vld_q[ra_idx];
  assign ra_tag     = tag_q[ra_idx];
  assign ra_last    = last_q[ra_idx];
  assign ra_pstride = pstr_q[ra_idx];
  assign ra_conf    = conf_q[ra_idx];

  assign rb_valid   = vld_q[rb_idx];
  assign rb_tag     = tag_q[rb_idx];
  assign rb_last    = last_q[rb_idx];
  assign rb_sstride = sstr_q[rb_idx];
  assign rb_pstride = pstr_q[rb_idx];
  assign rb_conf    = conf_q[rb_idx];
endmodule

// File: rtl/svp_train.sv
module svp_train
  import svp_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int TAG_W = 27
) (
  input  logic             upd_valid,
  input  logic             upd_writes_reg,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [VAL_W-1:0] upd_result,
  input  logic             e_valid,
  input  logic [TAG_W-1:0] e_tag,
  input  logic [VAL_W-1:0] e_last,
  input  logic [VAL_W-1:0] e_sstride,
  input  logic [VAL_W-1:0] e_pstride,
  input  conf_t            e_conf,
  output logic             we,
  output logic [VAL_W-1:0] n_last,
  output logic [VAL_W-1:0] n_sstride,
  output logic [VAL_W-1:0] n_pstride,
  output conf_t            n_conf,
  output logic             ev_hit,
  output logic             ev_alloc,
  output logic             ev_correct,
  output logic             ev_promote
);
  function automatic logic [VAL_W-1:0] delta(input logic [VAL_W-1:0] a,
                                             input logic [VAL_W-1:0] b);
    return a - b;
  endfunction

  logic             take;
  logic             match;
  logic [VAL_W-1:0] old_pred;
  logic [VAL_W-1:0] diff;

  assign take     = upd_valid && upd_writes_reg;
  assign match    = e_valid && (e_tag == upd_tag);
  assign old_pred = e_last + e_pstride;
  assign diff     = delta(upd_result, e_last);

  assign we         = take;
  assign ev_hit     = take && match;
  assign ev_alloc   = take && !match;
  assign ev_correct = ev_hit && (old_pred == upd_result);
  assign ev_promote = ev_hit && (diff == e_sstride);

  always_comb begin
    if (ev_hit) begin
      n_last    = upd_result;
      n_sstride = diff;
      n_pstride = ev_promote ? diff : e_pstride;
      n_conf    = conf_step(e_conf, ev_correct);
    end else begin
      n_last    = upd_result;
      n_sstride = '0;
      n_pstride = '0;
      n_conf    = '0;
    end
  end
endmodule

// File: rtl/svp_lookup.sv
module svp_lookup
  import svp_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_writes_reg,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             e_valid,
  input  logic [TAG_W-1:0] e_tag,
  input  logic [VAL_W-1:0] e_last,
  input  logic [VAL_W-1:0] e_pstride,
  input  conf_t            e_conf,
  output logic             pred_hit,
  output logic [VAL_W-1:0] pred_value,
  output logic             pred_confident
);
  logic found;
  assign found = lk_valid && lk_writes_reg && e_valid && (e_tag == lk_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_hit       <= 1'b0;
      pred_value     <= '0;
      pred_confident <= 1'b0;
    end else begin
      pred_hit       <= found;
      pred_value     <= found ? (e_last + e_pstride) : '0;
      pred_confident <= found && conf_trusted(e_conf);
    end
  end
endmodule

// File: rtl/stride_vpred.sv
module stride_vpred
  import svp_pkg::*;
#(
  parameter int VAL_W   = 32,
  parameter int PC_W    = 32,
  parameter int ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_writes_reg,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             pred_hit,
  output logic [VAL_W-1:0] pred_value,
  output logic             pred_confident,
  input  logic             upd_valid,
  input  logic             upd_writes_reg,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [VAL_W-1:0] upd_result
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[PC_W-1:IDX_W];
  assign up_idx = upd_pc[IDX_W-1:0];
  assign up_tag = upd_pc[PC_W-1:IDX_W];

  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [VAL_W-1:0] a_last, a_pstr, b_last, b_sstr, b_pstr;
  conf_t            a_conf, b_conf;

  logic             we;
  logic [VAL_W-1:0] n_last, n_sstr, n_pstr;
  conf_t            n_conf;

  // internal events, observed by the checker
  logic ev_hit, ev_alloc, ev_correct, ev_promote;

  svp_table #(.VAL_W(VAL_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(lk_idx), .ra_valid(a_valid), .ra_tag(a_tag), .ra_last(a_last),
    .ra_pstride(a_pstr), .ra_conf(a_conf),
    .rb_idx(up_idx), .rb_valid(b_valid), .rb_tag(b_tag), .rb_last(b_last),
    .rb_sstride(b_sstr), .rb_pstride(b_pstr), .rb_conf(b_conf),
    .we(we), .w_idx(up_idx), .w_tag(up_tag), .w_last(n_last),
    .w_sstride(n_sstr), .w_pstride(n_pstr), .w_conf(n_conf)
  );

  svp_train #(.VAL_W(VAL_W), .TAG_W(TAG_W)) u_trn (
    .upd_valid(upd_valid), .upd_writes_reg(upd_writes_reg), .upd_tag(up_tag),
    .upd_result(upd_result), .e_valid(b_valid), .e_tag(b_tag), .e_last(b_last),
    .e_sstride(b_sstr), .e_pstride(b_pstr), .e_conf(b_conf),
    .we(we), .n_last(n_last), .n_sstride(n_sstr), .n_pstride(n_pstr),
    .n_conf(n_conf), .ev_hit(ev_hit), .ev_alloc(ev_alloc),
    .ev_correct(ev_correct), .ev_promote(ev_promote)
  );

  svp_lookup #(.VAL_W(VAL_W), .TAG_W(TAG_W)) u_lk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_writes_reg(lk_writes_reg),
    .lk_tag(lk_tag), .e_valid(a_valid), .e_tag(a_tag), .e_last(a_last),
    .e_pstride(a_pstr), .e_conf(a_conf),
    .pred_hit(pred_hit), .pred_value(pred_value), .pred_confident(pred_confident)
  );
endmodule

// File: rtl/svp_chk.sv
module svp_chk #(
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_writes_reg,
  input logic             pred_hit,
  input logic [VAL_W-1:0] pred_value,
  input logic             pred_confident,
  input logic             upd_valid,
  input logic             upd_writes_reg,
  input logic             ev_hit,
  input logic             ev_alloc,
  input logic             ev_correct,
  input logic             ev_promote
);
  p_conf_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_confident |-> pred_hit);

  p_miss_value_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_value == '0));

  p_nonwrite_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_writes_reg) |=> !pred_hit);

  p_idle_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!pred_hit && !pred_confident));

  p_promote_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_promote |-> ev_hit);

  p_alloc_not_scored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !ev_correct);

  p_nonwrite_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_writes_reg) |-> (!ev_hit && !ev_alloc));
endmodule

bind stride_vpred svp_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_writes_reg(lk_writes_reg),
  .pred_hit(pred_hit), .pred_value(pred_value), .pred_confident(pred_confident),
  .upd_valid(upd_valid), .upd_writes_reg(upd_writes_reg),
  .ev_hit(ev_hit), .ev_alloc(ev_alloc), .ev_correct(ev_correct),
  .ev_promote(ev_promote)
);

// File: tb/sim_stride_vpred.sv
module sim_stride_vpred;
  localparam int VW = 32;
  localparam int PW = 32;
  localparam int NE = 32;
  localparam int IW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic lk_valid = 0, lk_writes_reg = 0;
  logic [PW-1:0] lk_pc = '0;
  logic pred_hit, pred_confident;
  logic [VW-1:0] pred_value;
  logic upd_valid = 0, upd_writes_reg = 0;
  logic [PW-1:0] upd_pc = '0;
  logic [VW-1:0] upd_result = '0;

  always #10 clk = ~clk;

  stride_vpred #(.VAL_W(VW), .PC_W(PW), .ENTRIES(NE)) u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // reference table
  bit          m_v [NE];
  logic [PW-1:0] m_pc [NE];
  logic [VW-1:0] m_last [NE], m_s1 [NE], m_s2 [NE];
  int          m_c [NE];

  function automatic logic [33:0] expect_lk(input logic [PW-1:0] pc, input bit wr);
    int i = int'(pc % NE);
    if (!wr || !m_v[i] || (m_pc[i] / NE) != (pc / NE)) return 34'd0;
    return {1'b1, (m_c[i] > 1), m_last[i] + m_s2[i]};
  endfunction

  function automatic void model_upd(input logic [PW-1:0] pc, input logic [VW-1:0] r, input bit wr);
    int i = int'(pc % NE);
    logic [VW-1:0] d;
    if (!wr) return;
    if (!m_v[i] || (m_pc[i] / NE) != (pc / NE)) begin
      m_v[i] = 1; m_pc[i] = pc; m_last[i] = r; m_s1[i] = 0; m_s2[i] = 0; m_c[i] = 0;
      return;
    end
    if (m_last[i] + m_s2[i] == r) m_c[i] = (m_c[i] < 3) ? m_c[i] + 1 : 3;
    else                          m_c[i] = (m_c[i] > 0) ? m_c[i] - 1 : 0;
    d = r - m_last[i];
    if (d == m_s1[i]) m_s2[i] = d;
    m_s1[i] = d;
    m_last[i] = r;
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hit=%b conf=%b val=%h expected hit=%b conf=%b val=%h",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // lookup and/or update in one cycle; lookup result checked next cycle
  task automatic cycle(input bit dl, input logic [PW-1:0] lpc, input bit lwr,
                       input bit du, input logic [PW-1:0] upc, input logic [VW-1:0] r,
                       input bit uwr, input string req);
    logic [33:0] exp;
    @(negedge clk);
    lk_valid = dl; lk_pc = lpc; lk_writes_reg = lwr;
    upd_valid = du; upd_pc = upc; upd_result = r; upd_writes_reg = uwr;
    exp = dl ? expect_lk(lpc, lwr) : 34'd0;
    if (du) model_upd(upc, r, uwr);
    @(negedge clk);
    lk_valid = 0; upd_valid = 0;
    if (dl) check(req, {pred_hit, pred_confident, pred_value}, exp);
  endtask

  task automatic look(input logic [PW-1:0] pc, input string req);
    cycle(1, pc, 1, 0, '0, '0, 0, req);
  endtask
  task automatic upd(input logic [PW-1:0] pc, input logic [VW-1:0] r);
    cycle(0, '0, 0, 1, pc, r, 1, "");
  endtask

  initial begin
    logic [VW-1:0] sv [8];
    int sk;
    void'($urandom(32'd4711));
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    look(32'h0000_0040, "R1 empty after reset");
    check("R1 outputs idle", {pred_hit, pred_confident, pred_value}, 34'd0);
    // R6 allocation, R3/R4/R5/R7 stride training
    upd(32'h40, 10);  look(32'h40, "R6 alloc last=10 strides 0");
    upd(32'h40, 14);  look(32'h40, "R4 first diff not promoted");
    upd(32'h40, 18);  look(32'h40, "R4 repeated diff promoted, R3 pred=22");
    check("R3 value 22", {2'b0, pred_value}, {2'b0, 32'd22});
    upd(32'h40, 22);  upd(32'h40, 26);
    look(32'h40, "R5 confident after two correct");
    check("R5 confident flag", {33'd0, pred_confident}, {33'd0, 1'b1});
    upd(32'h40, 100); look(32'h40, "R4 outlier keeps stride 4, R7 wrong drops conf");
    check("R4 pred after outlier", {2'b0, pred_value}, {2'b0, 32'd104});
    upd(32'h40, 104); look(32'h40, "R5 correct again");
    // R2 same-cycle lookup and update
    cycle(1, 32'h40, 1, 1, 32'h40, 108, 1, "R2 lookup sees pre-update state");
    look(32'h40, "R2 following lookup sees update");
    // R9 alias: same index, other tag
    look(32'h0000_0440, "R9 other tag misses");
    upd(32'h440, 7); look(32'h40, "R6 replaced entry misses");
    look(32'h440, "R6 new owner hits");
    // wrap-around R3
    upd(32'h84, 32'hFFFF_FFF8); upd(32'h84, 32'hFFFF_FFFB); upd(32'h84, 32'hFFFF_FFFE);
    look(32'h84, "R3 wraps to 1");
    check("R3 wrap value", {2'b0, pred_value}, {2'b0, 32'h1});
    // R8 non-writing
    cycle(1, 32'h84, 0, 0, '0, '0, 0, "R8 non-writing lookup misses");
    cycle(0, '0, 0, 1, 32'h84, 32'h1234, 0, "");
    look(32'h84, "R8 non-writing update ignored");
    // random streams
    for (int k = 0; k < 8; k++) sv[k] = $urandom;
    for (int it = 0; it < 3000; it++) begin
      logic [PW-1:0] pc;
      int k = int'($urandom % 8);
      pc = (k < 2) ? {24'd0, 3'(k + 1), 5'd9} : {24'd0, 3'd0, 5'(k * 3)};
      case (k % 4)
        0: sk = 0;
        1: sk = k + 1;
        2: sk = ((it / 40) % 2) ? 7 : -3;
        default: sk = int'($urandom);
      endcase
      sv[k] = sv[k] + VW'(sk);
      if ($urandom % 6 == 0)
        cycle(1, pc, 1, 1, pc, sv[k], 1, "R2 random concurrent");
      else begin
        cycle(1, pc, ($urandom % 10) != 0, 0, '0, '0, 0, "R3 R5 random lookup");
        cycle(0, '0, 0, 1, pc, sv[k], ($urandom % 12) != 0, "");
      end
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got running expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule